// File: doc/BRIEF.md
# NAND Page ECC Engine

This block builds error-detection codes in hardware for data moving between a host and a raw NAND device. It observes each byte that passes through the controller's data register and folds it into a line-and-column parity code. Each 256-byte chunk gets one 3-byte code. With the default of two chunks, a 512-byte page yields six code bytes. Software corrects single-bit errors by comparing a code stored in the spare area with the code computed on read. That comparison stays in software.

A 2-bit mode field controls the engine. The four settings are: clear, idle, accumulate, and read-out. The usual sequence is as follows. Software clears the engine and returns it to idle. It switches to accumulate for the duration of the page transfer, then goes back to idle. Finally it selects read-out, where each read of the data register returns the next code byte. Within a chunk the bytes come out in a fixed permuted order: the upper line byte, then the lower line byte, then the column byte.

Top module: `nand_ecc_engine`

## Requirements
- R1: A write strobe `mode_we` loads `mode_field` into `ecc_mode`, and the new value is visible from the next clock edge. Reset sets `ecc_mode` to 2'b00 (idle). The encodings are 2'b11 clear, 2'b00 idle, 2'b01 accumulate and 2'b10 read-out.
- R2: Each clock edge seen with `ecc_mode` = clear zeroes all parity state, the byte position and the read-out position. The same holds after reset. From that state every code byte reads 8'hFF.
- R3: A byte strobe `byte_valid` adds `byte_data` to the code only when `ecc_mode` = accumulate. In any other mode it leaves the code unchanged.
- R4: Accumulated bytes 0 to 255 go to chunk 0 and bytes 256 to 511 go to chunk 1. Bytes beyond CHUNKS*256 are ignored.
- R5: Let p be the XOR of all eight bits of a byte at chunk offset a. For each address bit k (0..7), line bit L[2k+1] is the XOR of p over bytes with a[k]=1, and L[2k] is the same over bytes with a[k]=0. The lower line byte is ~L[7:0] and the upper line byte is ~L[15:8].
- R6: The column byte is {~C5,~C4,~C3,~C2,~C1,~C0,1,1}. Each Cn is an XOR over every byte of the chunk:
  - C0 uses data bits 0,2,4,6.
  - C1 uses bits 1,3,5,7.
  - C2 uses bits 0,1,4,5.
  - C3 uses bits 2,3,6,7.
  - C4 uses bits 0..3.
  - C5 uses bits 4..7.
- R7: In read-out mode `code_byte` shows the current code byte and each `code_rd` advances to the next. The order is chunk 0 then chunk 1, and within a chunk it is upper line byte, lower line byte, column byte. After 3*CHUNKS reads the position wraps to the first byte.
- R8: `code_rd` outside read-out mode does not move the read-out position.
- R9: Two chunks that differ in exactly one data bit produce codes whose XOR has exactly 11 bits set (8 line, 3 column).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Write strobe for the ECC mode field |
| mode_field | input | 2 | New ECC mode value |
| byte_valid | input | 1 | A data byte crosses the data register this cycle |
| byte_data | input | 8 | The byte crossing the data register |
| code_rd | input | 1 | Data-register read of a code byte |
| ecc_mode | output | 2 | Current ECC mode |
| code_byte | output | 8 | Code byte at the current read-out position |

## Verification
Each result has a fixed latency:
- A mode write shows on `ecc_mode` one edge after the strobe.
- A clear acts on the edge after that, so a clear followed at once by an idle write still clears.
- A byte joins the parity on the edge where it is presented in accumulate mode.
- `code_byte` is combinational from the read-out position and parity registers. It changes only on the edge that takes a `code_rd`.

The bench drives every input at the falling edge and samples `code_byte` at the falling edge before issuing the read pulse. Each sample therefore reflects the position before advance.

// File: rtl/nand_ecc_pkg.sv
// Package: shared mode encoding, chunk geometry and column-parity helper
// for the NAND page ECC engine. Assumes 8-bit data and 256-byte chunks.
package nand_ecc_pkg;

    localparam int CHUNK_BYTES = 256;
    localparam int ADDR_W      = 8;
    localparam int LINE_W      = 2 * ADDR_W;
    localparam int COL_W       = 6;

    typedef enum logic [1:0] {
        ECC_IDLE  = 2'b00,
        ECC_ACCUM = 2'b01,
        ECC_DUMP  = 2'b10,
        ECC_CLEAR = 2'b11
    } ecc_mode_e;

    // Six column parities of one byte, grouped by bit-index halves.
    function automatic logic [COL_W-1:0] col_parity(input logic [7:0] b);
        logic [COL_W-1:0] c;
        c[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
        c[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
        c[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
        c[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
        c[4] = b[0] ^ b[1] ^ b[2] ^ b[3];
        c[5] = b[4] ^ b[5] ^ b[6] ^ b[7];
        return c;
    endfunction

endpackage

// File: rtl/ecc_mode_reg.sv
// Module: ecc_mode_reg
// Holds the 2-bit ECC mode written by software and decodes it into the
// clear, accumulate and read-out enables. Assumes the write strobe is a
// single-cycle pulse aligned to clk.
module ecc_mode_reg
    import nand_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [1:0] mode_field,
    output ecc_mode_e  mode_q,
    output logic       clr,
    output logic       accum,
    output logic       dump
);

    // Mode register: loads the field on a write, idles after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= ECC_IDLE;
        else if (mode_we) mode_q <= ecc_mode_e'(mode_field);
    end

    // Decode the held mode into one enable per action.
    always_comb begin
        clr   = (mode_q == ECC_CLEAR);
        accum = (mode_q == ECC_ACCUM);
        dump  = (mode_q == ECC_DUMP);
    end

    assert_mode_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> mode_q == $past(mode_field));

    assert_mode_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr, accum, dump}));

endmodule

// File: rtl/ecc_byte_counter.sv
// Module: ecc_byte_counter
// Counts accumulated bytes across the page and splits the count into a
// chunk select and a byte offset within the chunk. Saturates once the
// page is full, so further bytes are not taken.
module ecc_byte_counter
    import nand_ecc_pkg::*;
#(
    parameter int CHUNKS = 2,
    localparam int TOTAL = CHUNKS * CHUNK_BYTES,
    localparam int CNT_W = $clog2(TOTAL + 1),
    localparam int SEL_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              accum,
    input  logic              byte_valid,
    output logic              take,
    output logic [ADDR_W-1:0] addr,
    output logic [SEL_W-1:0]  sel
);

    logic [CNT_W-1:0] cnt_q;
    logic             full;

    // Accept a byte only in accumulate mode and while the page has room.
    always_comb begin
        full = (cnt_q == CNT_W'(TOTAL));
        take = accum && byte_valid && !full;
        addr = cnt_q[ADDR_W-1:0];
        sel  = SEL_W'(cnt_q >> ADDR_W);
    end

    // Position counter: zeroed by reset or clear, bumped per taken byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (take)     cnt_q <= cnt_q + 1'b1;
    end

    assert_count_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

    assert_count_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(accum && byte_valid)) |=> $stable(cnt_q));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(TOTAL));

endmodule

// File: rtl/ecc_chunk_parity.sv
// Module: ecc_chunk_parity
// Line and column parity accumulator for one 256-byte chunk. Emits the
// inverted code as {column byte, upper line byte, lower line byte}.
// Assumes at most one byte per cycle and that clear and add never coincide.
module ecc_chunk_parity
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic [23:0]       code
);

    logic [LINE_W-1:0] lp_q;
    logic [COL_W-1:0]  cp_q;
    logic [LINE_W-1:0] line_mask;
    logic              byte_par;

    assign byte_par = ^data;

    // Steer the byte parity into the odd or even line bit of each address bit.
    for (genvar k = 0; k < ADDR_W; k++) begin : g_line
        assign line_mask[2*k+1] = byte_par &  addr[k];
        assign line_mask[2*k]   = byte_par & ~addr[k];
    end

    // Parity registers: cleared together, folded in per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lp_q <= '0;
            cp_q <= '0;
        end else if (add) begin
            lp_q <= lp_q ^ line_mask;
            cp_q <= cp_q ^ col_parity(data);
        end
    end

    // Pack inverted parities; the two spare column bits read as ones.
    assign code = {~cp_q, 2'b11, ~lp_q[15:8], ~lp_q[7:0]};

    assert_parity_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lp_q == '0) && (cp_q == '0));

    assert_parity_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add) |=> $stable(lp_q) && $stable(cp_q));

    assert_line_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clr) |=> $countones(lp_q ^ $past(lp_q)) == ((^$past(data)) ? ADDR_W : 0));

endmodule

// File: rtl/ecc_readout_seq.sv
// Module: ecc_readout_seq
// Read-out position for the code bytes: a slot within the chunk (0..2)
// and a chunk index. Advances on each data-register read in read-out mode
// and wraps after the last byte of the last chunk.
module ecc_readout_seq
    import nand_ecc_pkg::*;
#(
    parameter int CHUNKS = 2,
    localparam int SEL_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
    localparam logic [SEL_W-1:0] LAST = SEL_W'(CHUNKS - 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             dump,
    input  logic             code_rd,
    output logic [1:0]       slot,
    output logic [SEL_W-1:0] chunk
);

    logic step;
    assign step = dump && code_rd;

    // Position register: slot steps 0,1,2 then the chunk moves on.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            slot  <= '0;
            chunk <= '0;
        end else if (step) begin
            if (slot == 2'd2) begin
                slot  <= '0;
                chunk <= (chunk == LAST) ? '0 : chunk + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    assert_slot_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slot != 2'd3);

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && slot == 2'd2 && chunk == LAST) |=> (slot == 2'd0) && (chunk == '0));

    assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(slot) && $stable(chunk));

endmodule

// File: rtl/nand_ecc_engine.sv
// Module: nand_ecc_engine (top)
// Hardware ECC generator beside a NAND data register: accumulates one
// 3-byte code per 256-byte chunk under a 2-bit mode field and returns the
// codes through the data register in a permuted order. Assumes at most
// one byte and one read per cycle.
module nand_ecc_engine
    import nand_ecc_pkg::*;
#(
    parameter int CHUNKS = 2,
    localparam int SEL_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [1:0] mode_field,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       code_rd,
    output logic [1:0] ecc_mode,
    output logic [7:0] code_byte
);

    ecc_mode_e         mode_q;
    logic              clr, accum, dump;
    logic              take;
    logic [ADDR_W-1:0] addr;
    logic [SEL_W-1:0]  sel;
    logic [1:0]        rd_slot;
    logic [SEL_W-1:0]  rd_chunk;
    logic [23:0]       codes [CHUNKS];
    logic [23:0]       cur_code;

    ecc_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_field (mode_field),
        .mode_q     (mode_q),
        .clr        (clr),
        .accum      (accum),
        .dump       (dump)
    );

    ecc_byte_counter #(.CHUNKS(CHUNKS)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .accum      (accum),
        .byte_valid (byte_valid),
        .take       (take),
        .addr       (addr),
        .sel        (sel)
    );

    // One parity accumulator per chunk, enabled by the chunk select.
    for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
        ecc_chunk_parity u_par (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .add   (take && (sel == SEL_W'(c))),
            .addr  (addr),
            .data  (byte_data),
            .code  (codes[c])
        );
    end

    ecc_readout_seq #(.CHUNKS(CHUNKS)) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .dump    (dump),
        .code_rd (code_rd),
        .slot    (rd_slot),
        .chunk   (rd_chunk)
    );

    // Pick the chunk addressed by the read-out position.
    always_comb begin
        cur_code = codes[0];
        for (int c = 0; c < CHUNKS; c++)
            if (rd_chunk == SEL_W'(c)) cur_code = codes[c];
    end

    // Permuted byte order within a chunk: upper line, lower line, column.
    always_comb begin
        case (rd_slot)
            2'd0:    code_byte = cur_code[15:8];
            2'd1:    code_byte = cur_code[7:0];
            default: code_byte = cur_code[23:16];
        endcase
    end

    assign ecc_mode = mode_q;

    assert_spare_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_slot == 2'd2) |-> (code_byte[1:0] == 2'b11));

endmodule

// File: tb/test_nand_ecc_engine.sv
module test_nand_ecc_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_field = 2'b00;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       code_rd = 1'b0;
    logic [1:0] ecc_mode;
    logic [7:0] code_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    nand_ecc_engine #(.CHUNKS(2)) i_nand_ecc_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_field (mode_field),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .code_rd    (code_rd),
        .ecc_mode   (ecc_mode),
        .code_byte  (code_byte)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [7:0]  seed;
        logic [10:0] count;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 8'hA5, 11'd512},
        '{3'd1, 8'h13, 11'd512},
        '{3'd2, 8'h6C, 11'd300},
        '{3'd3, 8'd200, 11'd512},
        '{3'd4, 8'h3C, 11'd100},
        '{3'd2, 8'h91, 11'd520}
    };

    function automatic logic [7:0] gen(input logic [2:0] kind, input logic [7:0] seed, input int i);
        logic [9:0] ii;
        ii = 10'(i);
        case (kind)
            3'd0:    return seed;
            3'd1:    return ii[7:0] + seed;
            3'd2:    return 8'(i * 37 + int'(seed)) ^ ii[9:2];
            3'd3:    return (i == int'(seed)) ? 8'h5A : 8'h00;
            3'd4:    return ii[0] ? seed : ~seed;
            default: return (ii[7:0] + seed) ^ ((i == 77) ? 8'h08 : 8'h00);
        endcase
    endfunction

    // Reference code for one chunk, written from R5 and R6: {col, upper, lower}.
    function automatic logic [23:0] model_chunk(input logic [2:0] kind, input logic [7:0] seed,
                                                input int count, input int c);
        logic [15:0] lp = '0;
        logic [5:0]  cp = '0;
        for (int i = 0; i < 256; i++) begin
            int g = c * 256 + i;
            if (g < count && g < 512) begin
                logic [7:0] b = gen(kind, seed, g);
                logic p = ^b;
                for (int k = 0; k < 8; k++) begin
                    if ((i >> k) & 1) lp[2*k+1] ^= p;
                    else              lp[2*k]   ^= p;
                end
                for (int j = 0; j < 8; j++) begin
                    if (j & 1) cp[1] ^= b[j]; else cp[0] ^= b[j];
                    if (j & 2) cp[3] ^= b[j]; else cp[2] ^= b[j];
                    if (j & 4) cp[5] ^= b[j]; else cp[4] ^= b[j];
                end
            end
        end
        return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
    endfunction

    function automatic logic [7:0] pick(input logic [23:0] code, input int slot);
        case (slot)
            0:       return code[15:8];
            1:       return code[7:0];
            default: return code[23:16];
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [1:0] m);
        @(negedge clk);
        mode_we = 1'b1;
        mode_field = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic read_one(output logic [7:0] b);
        @(negedge clk);
        b = code_byte;
        code_rd = 1'b1;
        @(negedge clk);
        code_rd = 1'b0;
    endtask

    task automatic feed(input logic [2:0] kind, input logic [7:0] seed, input int n);
        write_mode(2'b11);
        write_mode(2'b00);
        write_mode(2'b01);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data = gen(kind, seed, i);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        write_mode(2'b00);
        write_mode(2'b10);
    endtask

    initial begin
        logic [7:0] got;
        logic [7:0] first;
        logic [23:0] ca, cb;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset mode is idle
        check({6'd0, ecc_mode}, 8'h00, "R1 reset mode");

        // R2: after reset every code byte is FF
        write_mode(2'b10);
        check({6'd0, ecc_mode}, 8'h02, "R1 mode load");
        for (int p = 0; p < 6; p++) begin
            read_one(got);
            check(got, 8'hFF, "R2 reset code");
        end

        // Table of vectors: R4, R5, R6, R7 order and wrap
        for (int v = 0; v < NVEC; v++) begin
            feed(VECS[v].kind, VECS[v].seed, int'(VECS[v].count));
            for (int p = 0; p < 6; p++) begin
                read_one(got);
                if (p == 0) first = got;
                check(got, pick(model_chunk(VECS[v].kind, VECS[v].seed, int'(VECS[v].count), p / 3), p % 3),
                      "R4 R5 R6 R7 vector byte");
            end
            read_one(got);
            check(got, first, "R7 wrap");
        end

        // R3: bytes outside accumulate mode are ignored
        write_mode(2'b11);
        write_mode(2'b00);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data = 8'(i * 7 + 1);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        write_mode(2'b10);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data = 8'h01;
        end
        @(negedge clk);
        byte_valid = 1'b0;
        for (int p = 0; p < 6; p++) begin
            read_one(got);
            check(got, 8'hFF, "R3 ignored bytes");
        end

        // R8: reads in idle mode do not move the position
        feed(3'd1, 8'h13, 512);
        write_mode(2'b00);
        for (int i = 0; i < 2; i++) read_one(got);
        write_mode(2'b10);
        read_one(got);
        check(got, pick(model_chunk(3'd1, 8'h13, 512, 0), 0), "R8 idle reads ignored");

        // R2: clear mid-readout wipes the codes
        write_mode(2'b11);
        write_mode(2'b00);
        write_mode(2'b10);
        read_one(got);
        check(got, 8'hFF, "R2 clear mid readout");

        // R9: a single flipped bit changes exactly 11 code bits
        feed(3'd1, 8'h05, 256);
        for (int p = 0; p < 3; p++) begin
            read_one(got);
            if (p == 0) ca[15:8] = got; else if (p == 1) ca[7:0] = got; else ca[23:16] = got;
        end
        feed(3'd5, 8'h05, 256);
        for (int p = 0; p < 3; p++) begin
            read_one(got);
            if (p == 0) cb[15:8] = got; else if (p == 1) cb[7:0] = got; else cb[23:16] = got;
        end
        check(8'($countones(ca ^ cb)), 8'd11, "R9 single bit distance");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, fails);
            $finish;
        end
    end

endmodule